// File: doc/BRIEF.md
# Flash Command Sequencer

This block decodes the stream of qualified bus writes that reaches a NOR-style flash device and tracks the device's operating mode. The recognised sequences are unlock pairs, program, chip or sector erase, erase suspend and resume, the identification (autoselect) query and the reset command. From these it raises one-cycle start pulses for the embedded program and erase operations. It also tells the read path whether a read should return array data, status or identification codes. The embedded operations are modelled by internal down-counters of configurable length. An external timeout flag can abort a running operation into an error mode.

Reads are never decoded. The read path supplies only the sector index of the address it is about to read, and the block answers with a select code. The storage array, sector protection and the real program and erase algorithms live elsewhere.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `mode_o` is 0 (read array), `rd_sel_o` is 0 (array), and `prog_start_o`, `erase_start_o` and `done_o` are low.
- R2: An unlock pair (data 0xAA at address 0x555, then data 0x55 at address 0x2AA) moves the mode to 1 and then to 2. A third write at address 0x555 then selects the next mode: data 0x90 gives autoselect (mode 10), 0xA0 gives program setup (mode 3), and 0x80 gives erase setup (mode 4). Addresses are compared on the full `wr_addr` width.
- R3: A write whose address or data does not fit the current step drops the sequence to its base mode. The base mode is read array (0), or erase suspend (9) when the sequence began in suspend. Erase setup is not accepted inside suspend.
- R4: Data 0xF0 at any address returns an unlock or setup stage to its base mode. In read array it has no effect.
- R5: In program setup, any write other than 0xF0 starts a program. The mode becomes 7 and `prog_start_o` is high during the first program cycle. The mode stays at 7 for PROG_LEN cycles and then returns to the base mode, with `done_o` high for that one following cycle.
- R6: Erase setup takes a second unlock pair (modes 5 and 6). Then either data 0x10 at address 0x555 erases the whole chip, or data 0x30 at any address erases the sector given by the top SECT_W address bits. The mode becomes 8, `erase_start_o` pulses for one cycle, and after ERASE_LEN running cycles the mode returns to 0 with a `done_o` pulse.
- R7: While a program or erase is running, every write is ignored, including 0xF0. The only exception is the suspend command during an erase.
- R8: Data 0xB0 during an erase moves the mode to 9 and freezes the erase count. Data 0x30 at any address in mode 9 resumes the erase. The total number of cycles spent in mode 8 is still ERASE_LEN.
- R9: During a suspend, including its unlock and setup stages, a read whose `rd_sector` is a sector being erased gets `rd_sel_o` 1 (status), and any other sector gets 0 (array). A chip erase covers every sector. A program started in suspend returns to mode 9 when it finishes, and the same rule applies afterwards.
- R10: In autoselect `rd_sel_o` is 2 (ID). Only 0xF0 leaves autoselect, going back to the base mode (9 if autoselect was entered from suspend).
- R11: `op_err` high while a program or erase runs moves the mode to 11 (error) with no `done_o`. Reads return status. Only 0xF0 leaves error; it goes to mode 0 and clears any suspended erase.
- R12: `op_err` in the final running cycle wins over completion, giving error. A suspend command in the final erase cycle loses to completion, giving mode 0 and `done_o`.
- R13: `rd_sel_o` is 1 (status) in modes 7, 8 and 11, and it is 0 in read array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Qualified write cycle, one clock wide |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data (command byte) |
| rd_sector | input | SECT_W | Sector index of the pending read address |
| op_err | input | 1 | Timeout error flag from the embedded operation |
| mode_o | output | 4 | Current operating mode code |
| rd_sel_o | output | 2 | Read source: 0 array, 1 status, 2 ID |
| prog_start_o | output | 1 | One-cycle pulse when a program begins |
| erase_start_o | output | 1 | One-cycle pulse when a new erase begins |
| done_o | output | 1 | One-cycle pulse after an operation completes |

## Verification
Several events can land on the same clock edge as the final running cycle of an embedded operation: a timer expiry, a timeout error and a suspend command. The bench counts cycles from each start pulse so that it can raise `op_err`, or issue the 0xB0 write, exactly in that last program or erase cycle. In that cycle the error must leave mode 11 with no `done_o`, while the suspend must be overtaken by completion (mode 0 with `done_o`). A third overlap is the 0xF0 write that reaches a running program; it is judged by the program still ending on its original cycle.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;

  typedef enum logic [3:0] {
    M_READ    = 4'd0,
    M_UNLK_A  = 4'd1,
    M_UNLK_B  = 4'd2,
    M_PSETUP  = 4'd3,
    M_ESETUP  = 4'd4,
    M_EUNLK_A = 4'd5,
    M_EUNLK_B = 4'd6,
    M_PROGRAM = 4'd7,
    M_ERASE   = 4'd8,
    M_SUSPEND = 4'd9,
    M_AUTOSEL = 4'd10,
    M_ERROR   = 4'd11
  } fcs_mode_e;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_STATUS = 2'd1,
    RD_ID     = 2'd2
  } fcs_rd_e;

  typedef enum logic [3:0] {
    K_NONE, K_UNL1, K_UNL2, K_AUTO, K_PROG, K_ESET,
    K_CHIP, K_SECT, K_SUSP, K_RST
  } fcs_kind_e;

  localparam logic [10:0] UNLOCK_A_ADDR = 11'h555;
  localparam logic [10:0] UNLOCK_B_ADDR = 11'h2AA;

  localparam logic [7:0] CMD_UNL1  = 8'hAA;
  localparam logic [7:0] CMD_UNL2  = 8'h55;
  localparam logic [7:0] CMD_AUTO  = 8'h90;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ESET  = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
  localparam logic [7:0] CMD_RST   = 8'hF0;

  // Modes in which an embedded operation consumes counter cycles
  function automatic logic mode_running(fcs_mode_e m);
    return (m == M_PROGRAM) || (m == M_ERASE);
  endfunction

  // Sector mask for an erase start: all sectors or exactly one
  function automatic logic [255:0] erase_mask(logic chip, logic [7:0] sect);
    logic [255:0] m;
    m = '0;
    if (chip) m = '1;
    else m[sect] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/fcs_decode.sv
`timescale 1ns/1ps
module fcs_decode
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output fcs_kind_e         kind
);

  localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(UNLOCK_A_ADDR);
  localparam logic [ADDR_W-1:0] A_SECOND = ADDR_W'(UNLOCK_B_ADDR);

  logic at_first, at_second;
  assign at_first  = (addr == A_FIRST);
  assign at_second = (addr == A_SECOND);

  always_comb begin
    kind = K_NONE;
    if (data == CMD_RST)       kind = K_RST;
    else if (data == CMD_SUSP) kind = K_SUSP;
    else if (data == CMD_SECT) kind = K_SECT;
    else if (at_first) begin
      unique case (data)
        CMD_UNL1: kind = K_UNL1;
        CMD_AUTO: kind = K_AUTO;
        CMD_PROG: kind = K_PROG;
        CMD_ESET: kind = K_ESET;
        CMD_CHIP: kind = K_CHIP;
        default:  kind = K_NONE;
      endcase
    end else if (at_second && data == CMD_UNL2) begin
      kind = K_UNL2;
    end
  end

endmodule

// File: rtl/fcs_timer.sv
`timescale 1ns/1ps
module fcs_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic hold,
  input  logic abort,
  output logic busy_o,
  output logic expire_o
);

  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (abort) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      cnt  <= CW'(LEN);
      busy <= 1'b1;
    end else if (busy && !hold) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end

  assign busy_o   = busy;
  assign expire_o = busy && !hold && (cnt == CW'(1));

endmodule

// File: rtl/fcs_rdsel.sv
`timescale 1ns/1ps
module fcs_rdsel
  import fcs_pkg::*;
#(
  parameter int SECT_W = 3
) (
  input  fcs_mode_e              mode,
  input  logic                   susp_ctx,
  input  logic [(1<<SECT_W)-1:0] sect_mask,
  input  logic [SECT_W-1:0]      rd_sector,
  output logic [1:0]             rd_sel
);

  localparam int NSECT = 1 << SECT_W;

  logic [NSECT-1:0] hit;

  for (genvar i = 0; i < NSECT; i++) begin : g_hit
    assign hit[i] = sect_mask[i] && (rd_sector == SECT_W'(i));
  end

  logic in_erased;
  assign in_erased = |hit;

  always_comb begin
    unique case (mode)
      M_PROGRAM, M_ERASE, M_ERROR: rd_sel = RD_STATUS;
      M_AUTOSEL:                   rd_sel = RD_ID;
      default:                     rd_sel = (susp_ctx && in_erased) ? RD_STATUS : RD_ARRAY;
    endcase
  end

endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SECT_W    = 3,
  parameter int PROG_LEN  = 16,
  parameter int ERASE_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic              op_err,
  output logic [3:0]        mode_o,
  output logic [1:0]        rd_sel_o,
  output logic              prog_start_o,
  output logic              erase_start_o,
  output logic              done_o
);

  localparam int NSECT = 1 << SECT_W;

  fcs_mode_e        state, nxt;
  logic             susp_ctx, nxt_susp;
  logic [NSECT-1:0] mask, nxt_mask;
  fcs_kind_e        wr_kind;
  fcs_mode_e        base;

  // Named internal events, also observed by the checker
  logic prog_load, erase_load, tmr_abort, done_ev;
  logic prog_busy, prog_expire, erase_busy, erase_expire;
  logic erase_hold;

  logic [SECT_W-1:0] wr_sect;
  assign wr_sect = wr_addr[ADDR_W-1 -: SECT_W];

  fcs_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (wr_addr),
    .data (wr_data),
    .kind (wr_kind)
  );

  fcs_timer #(.LEN(PROG_LEN)) u_prog_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (prog_load),
    .hold     (1'b0),
    .abort    (tmr_abort),
    .busy_o   (prog_busy),
    .expire_o (prog_expire)
  );

  assign erase_hold = (state != M_ERASE);

  fcs_timer #(.LEN(ERASE_LEN)) u_erase_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (erase_load),
    .hold     (erase_hold),
    .abort    (tmr_abort),
    .busy_o   (erase_busy),
    .expire_o (erase_expire)
  );

  assign base = susp_ctx ? M_SUSPEND : M_READ;

  always_comb begin
    nxt        = state;
    nxt_susp   = susp_ctx;
    nxt_mask   = mask;
    prog_load  = 1'b0;
    erase_load = 1'b0;
    tmr_abort  = 1'b0;
    done_ev    = 1'b0;
    unique case (state)
      M_PROGRAM: begin
        if (op_err) begin
          nxt       = M_ERROR;
          tmr_abort = 1'b1;
        end else if (prog_expire) begin
          nxt     = base;
          done_ev = 1'b1;
        end
      end
      M_ERASE: begin
        if (op_err) begin
          nxt       = M_ERROR;
          tmr_abort = 1'b1;
        end else if (erase_expire) begin
          nxt      = M_READ;
          nxt_mask = '0;
          done_ev  = 1'b1;
        end else if (wr_en && wr_kind == K_SUSP) begin
          nxt      = M_SUSPEND;
          nxt_susp = 1'b1;
        end
      end
      M_ERROR: begin
        if (wr_en && wr_kind == K_RST) begin
          nxt      = M_READ;
          nxt_susp = 1'b0;
          nxt_mask = '0;
        end
      end
      M_AUTOSEL: begin
        if (wr_en && wr_kind == K_RST) nxt = base;
      end
      M_READ: begin
        if (wr_en && wr_kind == K_UNL1) nxt = M_UNLK_A;
      end
      M_SUSPEND: begin
        if (wr_en) begin
          if (wr_kind == K_UNL1) nxt = M_UNLK_A;
          else if (wr_kind == K_SECT) begin
            nxt      = M_ERASE;
            nxt_susp = 1'b0;
          end
        end
      end
      M_UNLK_A: begin
        if (wr_en) nxt = (wr_kind == K_UNL2) ? M_UNLK_B : base;
      end
      M_UNLK_B: begin
        if (wr_en) begin
          if (wr_kind == K_AUTO) nxt = M_AUTOSEL;
          else if (wr_kind == K_PROG) nxt = M_PSETUP;
          else if (wr_kind == K_ESET && !susp_ctx) nxt = M_ESETUP;
          else nxt = base;
        end
      end
      M_PSETUP: begin
        if (wr_en) begin
          if (wr_kind == K_RST) nxt = base;
          else begin
            nxt       = M_PROGRAM;
            prog_load = 1'b1;
          end
        end
      end
      M_ESETUP: begin
        if (wr_en) nxt = (wr_kind == K_UNL1) ? M_EUNLK_A : base;
      end
      M_EUNLK_A: begin
        if (wr_en) nxt = (wr_kind == K_UNL2) ? M_EUNLK_B : base;
      end
      M_EUNLK_B: begin
        if (wr_en) begin
          if (wr_kind == K_CHIP || wr_kind == K_SECT) begin
            nxt        = M_ERASE;
            erase_load = 1'b1;
            nxt_mask   = NSECT'(erase_mask(wr_kind == K_CHIP, 8'(wr_sect)));
          end else begin
            nxt = base;
          end
        end
      end
      default: nxt = M_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= M_READ;
      susp_ctx      <= 1'b0;
      mask          <= '0;
      prog_start_o  <= 1'b0;
      erase_start_o <= 1'b0;
      done_o        <= 1'b0;
    end else begin
      state         <= nxt;
      susp_ctx      <= nxt_susp;
      mask          <= nxt_mask;
      prog_start_o  <= prog_load;
      erase_start_o <= erase_load;
      done_o        <= done_ev;
    end
  end

  assign mode_o = state;

  fcs_rdsel #(.SECT_W(SECT_W)) u_rdsel (
    .mode      (state),
    .susp_ctx  (susp_ctx),
    .sect_mask (mask),
    .rd_sector (rd_sector),
    .rd_sel    (rd_sel_o)
  );

endmodule

// File: rtl/fcs_checker.sv
`timescale 1ns/1ps
module fcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       op_err,
  input logic [3:0] mode_o,
  input logic [1:0] rd_sel_o,
  input logic       prog_start_o,
  input logic       erase_start_o,
  input logic       done_o,
  input logic       prog_busy,
  input logic       prog_expire,
  input logic       erase_busy
);

  // R7: a running program ignores writes until it expires or faults
  a_r7_program_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd7 && !op_err && !prog_expire) |=> (mode_o == 4'd7));

  // R7: program mode is always backed by a busy program counter
  a_r7_program_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd7) |-> prog_busy);

  // R8: erase mode is always backed by a live erase counter
  a_r8_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd8) |-> erase_busy);

  // R11: error is left only through the reset command
  a_r11_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd11 && !(wr_en && wr_data == 8'hF0)) |=> (mode_o == 4'd11));

  // R10: autoselect is left only through the reset command
  a_r10_autosel_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd10 && !(wr_en && wr_data == 8'hF0)) |=> (mode_o == 4'd10));

  // R10: identification codes are served only in autoselect
  a_r10_id_only_autosel: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_o == 2'd2) |-> (mode_o == 4'd10));

  // R13: busy and error modes serve status
  a_r13_status_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd7 || mode_o == 4'd8 || mode_o == 4'd11) |-> (rd_sel_o == 2'd1));

  // R5: completion lands in read array or suspend, straight after a running mode
  a_r5_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((mode_o == 4'd0 || mode_o == 4'd9) &&
                ($past(mode_o) == 4'd7 || $past(mode_o) == 4'd8)));

  // R12: a fault in a running mode wins over completion
  a_r12_error_beats_done: assert property (@(posedge clk) disable iff (!rst_n)
    (op_err && (mode_o == 4'd7 || mode_o == 4'd8)) |=> (mode_o == 4'd11 && !done_o));

  // R5: start and completion pulses never overlap
  a_r5_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start_o, erase_start_o, done_o}));

endmodule

bind flash_cmd_seq fcs_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .op_err        (op_err),
  .mode_o        (mode_o),
  .rd_sel_o      (rd_sel_o),
  .prog_start_o  (prog_start_o),
  .erase_start_o (erase_start_o),
  .done_o        (done_o),
  .prog_busy     (prog_busy),
  .prog_expire   (prog_expire),
  .erase_busy    (erase_busy)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;

  localparam int ADDR_W = 16;
  localparam int SECT_W = 3;
  localparam int PLEN   = 6;
  localparam int ELEN   = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [SECT_W-1:0] rd_sector = '0;
  logic              op_err = 1'b0;
  logic [3:0]        mode_o;
  logic [1:0]        rd_sel_o;
  logic              prog_start_o, erase_start_o, done_o;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_LEN(PLEN), .ERASE_LEN(ELEN)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sector(rd_sector), .op_err(op_err), .mode_o(mode_o), .rd_sel_o(rd_sel_o),
    .prog_start_o(prog_start_o), .erase_start_o(erase_start_o), .done_o(done_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(16'h0555, 8'hAA);
    wr(16'h02AA, 8'h55);
  endtask

  task automatic rd_check(input string tag, input int sect, input int exp);
    rd_sector = SECT_W'(sect);
    #0.5;
    check(tag, "rd_sel", int'(rd_sel_o), exp);
  endtask

  task automatic t_reset();
    check("R1", "mode", mode_o, 0);
    rd_check("R1", 5, 0);
    check("R1", "pulses", {prog_start_o, erase_start_o, done_o}, 0);
  endtask

  task automatic t_sequences();
    wr(16'h0555, 8'hAA); check("R2", "mode after AA", mode_o, 1);
    wr(16'h02AB, 8'h55); check("R3", "mode after bad addr", mode_o, 0);
    unlock();            check("R2", "mode after pair", mode_o, 2);
    wr(16'h0555, 8'h77); check("R3", "mode after bad cmd", mode_o, 0);
    wr(16'h02AA, 8'h55); check("R3", "out of order unlock", mode_o, 0);
    wr(16'h0000, 8'hF0); check("R4", "reset in read", mode_o, 0);
    wr(16'h0555, 8'hAA); wr(16'h1234, 8'hF0);
    check("R4", "reset after AA", mode_o, 0);
    unlock(); wr(16'h0555, 8'hA0); check("R2", "program setup", mode_o, 3);
    wr(16'h7777, 8'hF0); check("R4", "reset in prog setup", mode_o, 0);
    unlock(); wr(16'h0555, 8'h80); check("R2", "erase setup", mode_o, 4);
    unlock(); check("R6", "second pair", mode_o, 6);
    wr(16'h0123, 8'h10); check("R3", "chip erase bad addr", mode_o, 0);
    unlock(); wr(16'h0555, 8'h80); wr(16'h0000, 8'hF0);
    check("R4", "reset in erase setup", mode_o, 0);
    rd_check("R13", 0, 0);
  endtask

  task automatic t_program();
    unlock(); wr(16'h0555, 8'hA0); wr(16'h1234, 8'h5A);
    check("R5", "mode at start", mode_o, 7);
    check("R5", "prog_start", prog_start_o, 1);
    rd_check("R13", 2, 1);
    wr(16'h0000, 8'hF0);
    check("R7", "reset ignored", mode_o, 7);
    check("R5", "prog_start one cycle", prog_start_o, 0);
    repeat (PLEN - 2) @(negedge clk);
    check("R5", "mode in last cycle", mode_o, 7);
    check("R5", "done early", done_o, 0);
    @(negedge clk);
    check("R5", "mode after run", mode_o, 0);
    check("R5", "done", done_o, 1);
    @(negedge clk);
    check("R5", "done one cycle", done_o, 0);
  endtask

  task automatic t_autosel();
    unlock(); wr(16'h0555, 8'h90);
    check("R10", "mode", mode_o, 10);
    rd_check("R10", 1, 2);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55);
    check("R10", "other writes ignored", mode_o, 10);
    wr(16'h4321, 8'hF0);
    check("R10", "reset leaves", mode_o, 0);
  endtask

  task automatic t_suspend();
    unlock(); wr(16'h0555, 8'h80); unlock(); wr(16'h6000, 8'h30);
    check("R6", "sector erase mode", mode_o, 8);
    check("R6", "erase_start", erase_start_o, 1);
    repeat (3) @(negedge clk);
    wr(16'h0000, 8'hB0);
    check("R8", "suspended", mode_o, 9);
    rd_check("R9", 3, 1);
    rd_check("R9", 1, 0);
    repeat (5) @(negedge clk);
    check("R8", "frozen while suspended", mode_o, 9);
    wr(16'h0555, 8'hAA); wr(16'h0000, 8'h00);
    check("R3", "bad unlock in suspend", mode_o, 9);
    unlock(); wr(16'h0555, 8'h80);
    check("R3", "erase setup refused in suspend", mode_o, 9);
    unlock(); wr(16'h0555, 8'hA0);
    check("R9", "program setup in suspend", mode_o, 3);
    rd_check("R9", 3, 1);
    rd_check("R9", 0, 0);
    wr(16'h2000, 8'h11);
    check("R5", "program in suspend", mode_o, 7);
    repeat (PLEN - 1) @(negedge clk);
    check("R5", "program last cycle", mode_o, 7);
    @(negedge clk);
    check("R9", "back to suspend", mode_o, 9);
    check("R5", "done in suspend", done_o, 1);
    rd_check("R9", 3, 1);
    rd_check("R9", 6, 0);
    unlock(); wr(16'h0555, 8'h90);
    check("R10", "autoselect from suspend", mode_o, 10);
    rd_check("R10", 3, 2);
    wr(16'h0000, 8'hF0);
    check("R10", "reset to suspend", mode_o, 9);
    wr(16'h0000, 8'h30);
    check("R8", "resumed", mode_o, 8);
    check("R8", "no restart pulse", erase_start_o, 0);
    repeat (ELEN - 4 - 1) @(negedge clk);
    check("R8", "erase last cycle", mode_o, 8);
    @(negedge clk);
    check("R8", "erase total length", mode_o, 0);
    check("R6", "erase done", done_o, 1);
    rd_check("R13", 3, 0);
  endtask

  task automatic t_chip_error();
    unlock(); wr(16'h0555, 8'h80); unlock(); wr(16'h0555, 8'h10);
    check("R6", "chip erase mode", mode_o, 8);
    wr(16'h0000, 8'hB0);
    rd_check("R9", 0, 1);
    rd_check("R9", 7, 1);
    wr(16'h0000, 8'h30);
    op_err = 1'b1;
    @(negedge clk);
    op_err = 1'b0;
    check("R11", "error mode", mode_o, 11);
    check("R11", "no done", done_o, 0);
    rd_check("R11", 4, 1);
    wr(16'h0555, 8'hAA);
    check("R11", "other writes ignored", mode_o, 11);
    wr(16'h0000, 8'hF0);
    check("R11", "reset leaves error", mode_o, 0);
    rd_check("R11", 7, 0);
  endtask

  task automatic t_collide_err();
    unlock(); wr(16'h0555, 8'hA0); wr(16'h0042, 8'h24);
    repeat (PLEN - 1) @(negedge clk);
    check("R12", "still programming", mode_o, 7);
    op_err = 1'b1;
    @(negedge clk);
    op_err = 1'b0;
    check("R12", "error beats done", mode_o, 11);
    check("R12", "no done", done_o, 0);
    wr(16'h0000, 8'hF0);
  endtask

  task automatic t_collide_susp();
    unlock(); wr(16'h0555, 8'h80); unlock(); wr(16'h2000, 8'h30);
    repeat (ELEN - 1) @(negedge clk);
    check("R12", "still erasing", mode_o, 8);
    wr(16'h0000, 8'hB0);
    check("R12", "done beats suspend", mode_o, 0);
    check("R12", "done pulse", done_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sequences();
    t_program();
    t_autosel();
    t_suspend();
    t_chip_error();
    t_collide_err();
    t_collide_susp();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++;
    fails++;
    $display("FAIL watchdog: run incomplete got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule